// File: doc/BRIEF.md
# Legacy and Message Interrupt Combiner

This block folds four level-sensitive legacy interrupt lines (A, B, C, D) and one "message interrupts pending" indication into a single interrupt request toward the host processor. Each source has a sticky status bit and an enable bit. Both kinds of bit sit at fixed positions inside a pair of 32-bit registers.

Software reads the status register to see which sources fired. It writes ones to clear the bits it has serviced. It masks or unmasks a source by rewriting the enable register, normally as a read-modify-write that changes only that source's bit. The request output stays high while any enabled source has its status bit set. The message pending input is the non-empty flag of an external message store. Here it is treated only as one more level source.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status register and the enable register read 0, and `irq_o` is low.
- R2: A high level on `intx_i[k]` sets status bit 5+k in the next cycle. Line A maps to bit 5, B to bit 6, C to bit 7 and D to bit 8. The bit stays set after the line drops.
- R3: A high level on `msi_pend_i` sets status bit 3 in the next cycle. The bit stays set after the input drops.
- R4: A write to the status offset (0x0B1C) clears every status bit written as 1. Bits written as 0 are left unchanged.
- R5: If a source is still high in the cycle of a clear, its status bit stays set.
- R6: A write to the enable offset (0x0B0C) stores data bits 3 and 5..8. All other enable bits read 0. An enable write leaves the status register unchanged.
- R7: `irq_o` is high exactly when some status bit is set and its enable bit is also set. A masked source still records its event in the status register.
- R8: A read of any offset other than the two registers returns 0. A write to any other offset changes neither register. Unimplemented status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| intx_i | input | 4 | Legacy interrupt levels A..D, active high |
| msi_pend_i | input | 1 | Message interrupts pending (store non-empty) |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every source input and every register write strobe is sampled cleanly at the rising edge. They also assume that a write strobe lasts a single cycle for each intended write. Under those assumptions a set status bit can fall only through a write to the status offset. The bench changes every input at the falling clock edge and keeps each write strobe to exactly one cycle. It holds a source high across a clear only in the scenario that is meant to test that overlap.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_EN   = 2'd1,
    HIT_ST   = 2'd2
  } reg_hit_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  // a live event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= event_i | (q_q & ~clr_i);
  end
  assign q_o = q_q;
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] EN_OFS = 16'h0B0C,
  parameter logic [ADDR_W-1:0] ST_OFS = 16'h0B1C,
  parameter logic [DATA_W-1:0] IMPL   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] enable_o,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_hit_e hit;
  logic [DATA_W-1:0] enable_q;

  always_comb begin
    if (reg_addr_i == EN_OFS)      hit = HIT_EN;
    else if (reg_addr_i == ST_OFS) hit = HIT_ST;
    else                           hit = HIT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         enable_q <= '0;
    else if (reg_wr_i && hit == HIT_EN)  enable_q <= reg_wdata_i & IMPL;
  end

  assign clr_o    = (reg_wr_i && hit == HIT_ST) ? (reg_wdata_i & IMPL) : '0;
  assign enable_o = enable_q;

  always_comb begin
    unique case (hit)
      HIT_EN:  rdata_o = enable_q;
      HIT_ST:  rdata_o = status_i & IMPL;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_INTX   = 4,
  parameter int unsigned INTX_LSB = 5,
  parameter int unsigned MSI_BIT  = 3,
  parameter logic [ADDR_W-1:0] EN_OFS = 16'h0B0C,
  parameter logic [ADDR_W-1:0] ST_OFS = 16'h0B1C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INTX-1:0] intx_i,
  input  logic              msi_pend_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] INTX_MASK = DATA_W'(((1 << N_INTX) - 1) << INTX_LSB);
  localparam logic [DATA_W-1:0] MSI_MASK  = DATA_W'(1) << MSI_BIT;
  localparam logic [DATA_W-1:0] IMPL      = INTX_MASK | MSI_MASK;

  logic [DATA_W-1:0] ev, clr, status_q, enable_q;

  always_comb begin
    ev = '0;
    ev[INTX_LSB +: N_INTX] = intx_i;
    ev[MSI_BIT] = msi_pend_i;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_cell
      irq_src_cell u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .event_i(ev[b]),
        .clr_i  (clr[b]),
        .q_o    (status_q[b])
      );
    end else begin : g_tie
      assign status_q[b] = 1'b0;
    end
  end

  irq_csr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .EN_OFS(EN_OFS), .ST_OFS(ST_OFS), .IMPL(IMPL)
  ) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .status_i   (status_q),
    .enable_o   (enable_q),
    .clr_o      (clr),
    .rdata_o    (reg_rdata_o)
  );

  assign irq_o = |(status_q & enable_q);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_INTX   = 4,
  parameter int unsigned INTX_LSB = 5,
  parameter int unsigned MSI_BIT  = 3,
  parameter logic [ADDR_W-1:0] EN_OFS = 16'h0B0C,
  parameter logic [ADDR_W-1:0] ST_OFS = 16'h0B1C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_INTX-1:0] intx_i,
  input logic              msi_pend_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] enable_q,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] IMPL =
    DATA_W'(((1 << N_INTX) - 1) << INTX_LSB) | (DATA_W'(1) << MSI_BIT);

  logic st_wr, en_wr;
  assign st_wr = reg_wr_i && (reg_addr_i == ST_OFS);
  assign en_wr = reg_wr_i && (reg_addr_i == EN_OFS);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r1: assert (status_q == '0 && enable_q == '0 && !irq_o);
    end
  end

  for (genvar k = 0; k < N_INTX; k++) begin : g_intx
    p_intx_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      intx_i[k] |=> status_q[INTX_LSB + k]);
  end

  p_msi_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_pend_i |=> status_q[MSI_BIT]);

  p_msi_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && reg_wdata_i[MSI_BIT] && !msi_pend_i) |=> !status_q[MSI_BIT]);

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_clear_race_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && msi_pend_i) |=> status_q[MSI_BIT]);

  p_enable_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> (enable_q == ($past(reg_wdata_i) & IMPL)));

  p_enable_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr |=> $stable(enable_q));

  p_msi_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_pend_i && enable_q[MSI_BIT] && !en_wr) |=> irq_o);
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_INTX(N_INTX),
  .INTX_LSB(INTX_LSB), .MSI_BIT(MSI_BIT), .EN_OFS(EN_OFS), .ST_OFS(ST_OFS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .intx_i     (intx_i),
  .msi_pend_i (msi_pend_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .irq_o      (irq_o)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam logic [15:0] EN = 16'h0B0C;
  localparam logic [15:0] ST = 16'h0B1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx = '0;
  logic        msi = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_aggregator u0 (
    .clk_i(clk), .rst_ni(rst_n), .intx_i(intx), .msi_pend_i(msi),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_intx(input int k);
    @(negedge clk); intx[k] = 1'b1;
    @(negedge clk); intx[k] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_rd(ST, v); chk("R1 status", v, 32'h0);
    reg_rd(EN, v); chk("R1 enable", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_intx_latch;
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      pulse_intx(k);
      reg_rd(ST, v); chk("R2 line latch", v, 32'h1 << (5 + k));
      chk("R7 masked no irq", {31'b0, irq}, 32'h0);
      reg_wr(ST, 32'h1 << (5 + k));
      reg_rd(ST, v); chk("R4 clear", v, 32'h0);
    end
  endtask

  task automatic t_msi;
    logic [31:0] v;
    @(negedge clk); msi = 1'b1;
    @(negedge clk); msi = 1'b0;
    reg_rd(ST, v); chk("R3 msi latch", v, 32'h8);
    reg_wr(ST, 32'hFFFF_FFF7);
    reg_rd(ST, v); chk("R4 zero bit kept", v, 32'h8);
    reg_wr(ST, 32'h8);
    reg_rd(ST, v); chk("R4 msi clear", v, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); intx[2] = 1'b1;
    reg_wr(ST, 32'h80);
    reg_rd(ST, v); chk("R5 live line survives clear", v, 32'h80);
    @(negedge clk); intx[2] = 1'b0;
    reg_wr(ST, 32'h80);
    reg_rd(ST, v); chk("R4 clear after drop", v, 32'h0);
    @(negedge clk); msi = 1'b1;
    reg_wr(ST, 32'h8);
    reg_rd(ST, v); chk("R5 msi survives clear", v, 32'h8);
    @(negedge clk); msi = 1'b0;
    reg_wr(ST, 32'h8);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    pulse_intx(3);
    reg_wr(EN, 32'hFFFF_FFFF);
    reg_rd(EN, v); chk("R6 enable bits", v, 32'h1E8);
    reg_rd(ST, v); chk("R6 status untouched", v, 32'h100);
    chk("R7 enabled D irq", {31'b0, irq}, 32'h1);
    reg_wr(ST, 32'h100);
    reg_wr(EN, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    reg_wr(EN, 32'h40);
    pulse_intx(0);
    chk("R7 A masked", {31'b0, irq}, 32'h0);
    reg_rd(ST, v); chk("R7 masked still latched", v, 32'h20);
    pulse_intx(1);
    chk("R7 B enabled", {31'b0, irq}, 32'h1);
    reg_wr(ST, 32'h40);
    chk("R7 B cleared", {31'b0, irq}, 32'h0);
    reg_rd(EN, v);
    reg_wr(EN, v | 32'h20);
    reg_rd(EN, v); chk("R6 rmw unmask", v, 32'h60);
    chk("R7 A unmasked", {31'b0, irq}, 32'h1);
    reg_wr(EN, v & ~32'h20);
    chk("R7 A remasked", {31'b0, irq}, 32'h0);
    reg_wr(ST, 32'hFFFF_FFFF);
    reg_rd(ST, v); chk("R4 all cleared", v, 32'h0);
    reg_wr(EN, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    pulse_intx(2);
    reg_wr(EN, 32'h8);
    reg_rd(16'h0B10, v); chk("R8 unmapped read", v, 32'h0);
    reg_wr(16'h0B10, 32'hFFFF_FFFF);
    reg_wr(16'h0B0D, 32'hFFFF_FFFF);
    reg_rd(EN, v); chk("R8 enable kept", v, 32'h8);
    reg_rd(ST, v); chk("R8 status kept", v, 32'h80);
    reg_wr(ST, 32'h80);
    reg_wr(EN, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_intx_latch;
    t_msi;
    t_level;
    t_enable;
    t_irq;
    t_unmapped;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule